// File: doc/BRIEF.md
# Section-Based Remote Address Translator

This block sits on the request path of a compute-side memory endpoint. Every incoming cacheline request (128 bytes, read or write) carries an address in the endpoint's internal address space, which always starts at zero regardless of the host range assigned to the endpoint. The block rewrites that address into an effective address in the remote memory donor's space. It also attaches a network identifier that a later routing stage uses to steer the request.

The internal space is cut into equal, aligned sections. A fixed field of address bits selects one entry in a flat section table, one entry per section. Each entry holds a cacheline-granular offset, a network identifier and a legal flag. A configuration port writes one whole entry per cycle. Requests to a legal section go downstream with the translated address. Requests to a section not marked legal come back to the requester as an error response that carries their tag, and nothing is sent downstream for them. Both outcomes appear a fixed two cycles after the request is accepted, one request per cycle, in order.

Top module: `sect_xlate_top`

## Requirements
- R1: After reset every section is illegal and both `out_vld` and `err_vld` are low; a request issued before any table write returns an error.
- R2: The section index is `req_addr[SECT_LSB +: SECT_W]` (bits 31:28 with defaults), and requests whose addresses differ only below bit SECT_LSB use the same entry.
- R3: For a legal section, `out_addr` equals the request address with its index bits cleared (zero-extended to RA_W) plus the entry offset times 128, modulo 2^RA_W; `out_addr[6:0]` always equals `req_addr[6:0]`.
- R4: For a legal section, `out_net` equals the network identifier of the selected entry.
- R5: For an illegal section, `err_vld` pulses with `err_tag` equal to the request tag two cycles after the request, and `out_vld` stays low.
- R6: For a legal section, `out_vld` pulses with `out_tag` and `out_wr` equal to the request's two cycles after the request, and `err_vld` stays low.
- R7: A lookup in the same cycle as a configuration write to the same entry uses the entry's previous contents; later lookups use the new contents.
- R8: A configuration write changes only the addressed entry; writing the legal flag as 0 turns later requests to that section into errors.
- R9: Requests on consecutive cycles produce outputs on consecutive cycles in the same order; no output pulses without a request two cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write one section table entry |
| cfg_idx | input | SECT_W | Entry to write |
| cfg_off | input | RA_W-7 | Offset in 128-byte units |
| cfg_net | input | NETID_W | Network identifier for the entry |
| cfg_legal | input | 1 | 1 marks the section a legal destination |
| req_vld | input | 1 | Request present this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_tag | input | TAG_W | Requester tag |
| req_addr | input | SECT_LSB+SECT_W | Device-internal byte address |
| out_vld | output | 1 | Translated request valid |
| out_wr | output | 1 | Translated request direction |
| out_tag | output | TAG_W | Translated request tag |
| out_addr | output | RA_W | Remote effective address |
| out_net | output | NETID_W | Network identifier in the header |
| err_vld | output | 1 | Error response valid |
| err_tag | output | TAG_W | Tag of the failed request |

## Verification
The bench targets the top index value and a zero index, and an offset large enough that the sum wraps to zero; a design that took the index from the wrong bits or kept the index bits in the sum would emit wrong addresses there. It issues a lookup in the same cycle as a write to the same entry; a design with write-through reads would return the new identifier instead of the old one. It revokes one section and checks that a neighbour still translates; a decoder that wrote the wrong entry would corrupt the neighbour or keep forwarding to the revoked section. Back-to-back requests that mix legal and illegal sections expose any lost, duplicated or reordered response.

// File: rtl/sx_pkg.sv
package sx_pkg;
  localparam int CL_BITS = 7;  // 128-byte cacheline

  typedef enum logic [1:0] {
    SX_NONE = 2'd0,
    SX_FWD  = 2'd1,
    SX_FAIL = 2'd2
  } sx_kind_e;
endpackage

// File: rtl/sx_sect_table.sv
module sx_sect_table #(
  parameter int SECT_W  = 4,
  parameter int OFF_W   = 45,
  parameter int NETID_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SECT_W-1:0]  cfg_idx,
  input  logic [OFF_W-1:0]   cfg_off,
  input  logic [NETID_W-1:0] cfg_net,
  input  logic               cfg_legal,
  input  logic [SECT_W-1:0]  rd_idx,
  output logic [OFF_W-1:0]   rd_off,
  output logic [NETID_W-1:0] rd_net,
  output logic               rd_legal
);
  localparam int N_ENT = 1 << SECT_W;

  logic [OFF_W-1:0]   off_q   [N_ENT];
  logic [NETID_W-1:0] net_q   [N_ENT];
  logic               legal_q [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic               en;
    logic [OFF_W-1:0]   off_d;
    logic [NETID_W-1:0] net_d;
    logic               legal_d;

    always_comb begin
      en      = cfg_we && (cfg_idx == SECT_W'(g));
      off_d   = cfg_off;
      net_d   = cfg_net;
      legal_d = cfg_legal;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_q[g]   <= '0;
        net_q[g]   <= '0;
        legal_q[g] <= 1'b0;
      end else if (en) begin
        off_q[g]   <= off_d;
        net_q[g]   <= net_d;
        legal_q[g] <= legal_d;
      end
    end
  end

  // Read returns the registered contents: a write in this cycle is not seen.
  always_comb begin
    rd_off   = off_q[rd_idx];
    rd_net   = net_q[rd_idx];
    rd_legal = legal_q[rd_idx];
  end
endmodule

// File: rtl/sx_lookup_stage.sv
module sx_lookup_stage #(
  parameter int TAG_W    = 6,
  parameter int SECT_LSB = 28,
  parameter int OFF_W    = 45,
  parameter int NETID_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_vld,
  input  logic                req_wr,
  input  logic [TAG_W-1:0]    req_tag,
  input  logic [SECT_LSB-1:0] req_base,
  input  logic [OFF_W-1:0]    ent_off,
  input  logic [NETID_W-1:0]  ent_net,
  input  logic                ent_legal,
  output logic                s1_vld,
  output logic                s1_wr,
  output logic [TAG_W-1:0]    s1_tag,
  output logic [SECT_LSB-1:0] s1_base,
  output logic [OFF_W-1:0]    s1_off,
  output logic [NETID_W-1:0]  s1_net,
  output logic                s1_legal
);
  logic                vld_d;
  logic                ld_en;
  logic                wr_d;
  logic [TAG_W-1:0]    tag_d;
  logic [SECT_LSB-1:0] base_d;
  logic [OFF_W-1:0]    off_d;
  logic [NETID_W-1:0]  net_d;
  logic                legal_d;

  always_comb begin
    vld_d   = req_vld;
    ld_en   = req_vld;
    wr_d    = req_wr;
    tag_d   = req_tag;
    base_d  = req_base;
    off_d   = ent_off;
    net_d   = ent_net;
    legal_d = ent_legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_vld <= 1'b0;
    else        s1_vld <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_wr    <= 1'b0;
      s1_tag   <= '0;
      s1_base  <= '0;
      s1_off   <= '0;
      s1_net   <= '0;
      s1_legal <= 1'b0;
    end else if (ld_en) begin
      s1_wr    <= wr_d;
      s1_tag   <= tag_d;
      s1_base  <= base_d;
      s1_off   <= off_d;
      s1_net   <= net_d;
      s1_legal <= legal_d;
    end
  end
endmodule

// File: rtl/sx_xlate_stage.sv
module sx_xlate_stage
  import sx_pkg::*;
#(
  parameter int TAG_W    = 6,
  parameter int SECT_LSB = 28,
  parameter int OFF_W    = 45,
  parameter int NETID_W  = 8,
  parameter int RA_W     = OFF_W + CL_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s1_vld,
  input  logic                s1_wr,
  input  logic [TAG_W-1:0]    s1_tag,
  input  logic [SECT_LSB-1:0] s1_base,
  input  logic [OFF_W-1:0]    s1_off,
  input  logic [NETID_W-1:0]  s1_net,
  input  logic                s1_legal,
  output logic                out_vld,
  output logic                out_wr,
  output logic [TAG_W-1:0]    out_tag,
  output logic [RA_W-1:0]     out_addr,
  output logic [NETID_W-1:0]  out_net,
  output logic                err_vld,
  output logic [TAG_W-1:0]    err_tag
);
  sx_kind_e          kind;
  logic [RA_W-1:0]   base_ext;
  logic [RA_W-1:0]   off_ext;
  logic [RA_W-1:0]   addr_d;
  logic              fwd_en;
  logic              fail_en;

  always_comb begin
    if (!s1_vld)       kind = SX_NONE;
    else if (s1_legal) kind = SX_FWD;
    else               kind = SX_FAIL;
    base_ext = {{(RA_W-SECT_LSB){1'b0}}, s1_base};
    off_ext  = {s1_off, {CL_BITS{1'b0}}};
    addr_d   = base_ext + off_ext;
    fwd_en   = (kind == SX_FWD);
    fail_en  = (kind == SX_FAIL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      err_vld <= 1'b0;
    end else begin
      out_vld <= fwd_en;
      err_vld <= fail_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_wr   <= 1'b0;
      out_tag  <= '0;
      out_addr <= '0;
      out_net  <= '0;
    end else if (fwd_en) begin
      out_wr   <= s1_wr;
      out_tag  <= s1_tag;
      out_addr <= addr_d;
      out_net  <= s1_net;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_tag <= '0;
    else if (fail_en) err_tag <= s1_tag;
  end
endmodule

// File: rtl/sect_xlate_top.sv
module sect_xlate_top
  import sx_pkg::*;
#(
  parameter int SECT_LSB = 28,
  parameter int SECT_W   = 4,
  parameter int RA_W     = 52,
  parameter int NETID_W  = 8,
  parameter int TAG_W    = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [SECT_W-1:0]            cfg_idx,
  input  logic [RA_W-CL_BITS-1:0]      cfg_off,
  input  logic [NETID_W-1:0]           cfg_net,
  input  logic                         cfg_legal,
  input  logic                         req_vld,
  input  logic                         req_wr,
  input  logic [TAG_W-1:0]             req_tag,
  input  logic [SECT_LSB+SECT_W-1:0]   req_addr,
  output logic                         out_vld,
  output logic                         out_wr,
  output logic [TAG_W-1:0]             out_tag,
  output logic [RA_W-1:0]              out_addr,
  output logic [NETID_W-1:0]           out_net,
  output logic                         err_vld,
  output logic [TAG_W-1:0]             err_tag
);
  localparam int OFF_W = RA_W - CL_BITS;

  logic [SECT_W-1:0]   rd_idx;
  logic [SECT_LSB-1:0] req_base;
  logic [OFF_W-1:0]    ent_off;
  logic [NETID_W-1:0]  ent_net;
  logic                ent_legal;

  logic                s1_vld;
  logic                s1_wr;
  logic [TAG_W-1:0]    s1_tag;
  logic [SECT_LSB-1:0] s1_base;
  logic [OFF_W-1:0]    s1_off;
  logic [NETID_W-1:0]  s1_net;
  logic                s1_legal;

  always_comb begin
    rd_idx   = req_addr[SECT_LSB +: SECT_W];
    req_base = req_addr[SECT_LSB-1:0];
  end

  sx_sect_table #(
    .SECT_W (SECT_W),
    .OFF_W  (OFF_W),
    .NETID_W(NETID_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_off  (cfg_off),
    .cfg_net  (cfg_net),
    .cfg_legal(cfg_legal),
    .rd_idx   (rd_idx),
    .rd_off   (ent_off),
    .rd_net   (ent_net),
    .rd_legal (ent_legal)
  );

  sx_lookup_stage #(
    .TAG_W   (TAG_W),
    .SECT_LSB(SECT_LSB),
    .OFF_W   (OFF_W),
    .NETID_W (NETID_W)
  ) u_lookup (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (req_vld),
    .req_wr   (req_wr),
    .req_tag  (req_tag),
    .req_base (req_base),
    .ent_off  (ent_off),
    .ent_net  (ent_net),
    .ent_legal(ent_legal),
    .s1_vld   (s1_vld),
    .s1_wr    (s1_wr),
    .s1_tag   (s1_tag),
    .s1_base  (s1_base),
    .s1_off   (s1_off),
    .s1_net   (s1_net),
    .s1_legal (s1_legal)
  );

  sx_xlate_stage #(
    .TAG_W   (TAG_W),
    .SECT_LSB(SECT_LSB),
    .OFF_W   (OFF_W),
    .NETID_W (NETID_W),
    .RA_W    (RA_W)
  ) u_xlate (
    .clk     (clk),
    .rst_n   (rst_n),
    .s1_vld  (s1_vld),
    .s1_wr   (s1_wr),
    .s1_tag  (s1_tag),
    .s1_base (s1_base),
    .s1_off  (s1_off),
    .s1_net  (s1_net),
    .s1_legal(s1_legal),
    .out_vld (out_vld),
    .out_wr  (out_wr),
    .out_tag (out_tag),
    .out_addr(out_addr),
    .out_net (out_net),
    .err_vld (err_vld),
    .err_tag (err_tag)
  );
endmodule

// File: rtl/sx_checker.sv
module sx_checker #(
  parameter int TAG_W = 6,
  parameter int RA_W  = 52
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_vld,
  input logic             req_wr,
  input logic [TAG_W-1:0] req_tag,
  input logic [6:0]       req_lo,
  input logic             out_vld,
  input logic             out_wr,
  input logic [TAG_W-1:0] out_tag,
  input logic [RA_W-1:0]  out_addr,
  input logic             err_vld,
  input logic [TAG_W-1:0] err_tag
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_vld && err_vld)); // R5

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_vld, 2) |-> (out_vld || err_vld)); // R6

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_vld, 2) |-> (!out_vld && !err_vld)); // R9

  AST_FWD_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_tag == $past(req_tag, 2) && out_wr == $past(req_wr, 2))); // R6

  AST_ERR_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld |-> (err_tag == $past(req_tag, 2))); // R5

  AST_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_addr[6:0] == $past(req_lo, 2))); // R3
endmodule

bind sect_xlate_top sx_checker #(
  .TAG_W(TAG_W),
  .RA_W (RA_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_vld (req_vld),
  .req_wr  (req_wr),
  .req_tag (req_tag),
  .req_lo  (req_addr[6:0]),
  .out_vld (out_vld),
  .out_wr  (out_wr),
  .out_tag (out_tag),
  .out_addr(out_addr),
  .err_vld (err_vld),
  .err_tag (err_tag)
);

// File: tb/tb_sect_xlate_top.sv
`timescale 1ns/1ps
module tb_sect_xlate_top;
  localparam int SECT_LSB = 28;
  localparam int SECT_W   = 4;
  localparam int RA_W     = 52;
  localparam int NETID_W  = 8;
  localparam int TAG_W    = 6;
  localparam int OFF_W    = RA_W - 7;
  localparam int IA_W     = SECT_LSB + SECT_W;
  localparam int N_ENT    = 1 << SECT_W;
  localparam int N_VEC    = 8;

  logic               clk;
  logic               rst_n;
  logic               cfg_we;
  logic [SECT_W-1:0]  cfg_idx;
  logic [OFF_W-1:0]   cfg_off;
  logic [NETID_W-1:0] cfg_net;
  logic               cfg_legal;
  logic               req_vld;
  logic               req_wr;
  logic [TAG_W-1:0]   req_tag;
  logic [IA_W-1:0]    req_addr;
  logic               out_vld;
  logic               out_wr;
  logic [TAG_W-1:0]   out_tag;
  logic [RA_W-1:0]    out_addr;
  logic [NETID_W-1:0] out_net;
  logic               err_vld;
  logic [TAG_W-1:0]   err_tag;

  sect_xlate_top dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_off(cfg_off),
    .cfg_net(cfg_net), .cfg_legal(cfg_legal),
    .req_vld(req_vld), .req_wr(req_wr), .req_tag(req_tag), .req_addr(req_addr),
    .out_vld(out_vld), .out_wr(out_wr), .out_tag(out_tag), .out_addr(out_addr),
    .out_net(out_net), .err_vld(err_vld), .err_tag(err_tag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int  n_chk;
  int  n_fail;
  bit  done;

  // Bench-side model of the table
  logic [OFF_W-1:0]   m_off [N_ENT];
  logic [NETID_W-1:0] m_net [N_ENT];
  bit                 m_leg [N_ENT];

  // Vector: {wr, tag, addr}
  localparam bit [1+TAG_W+IA_W-1:0] VEC [N_VEC] = '{
    {1'b0, 6'd1,  32'h0000_0000},
    {1'b1, 6'd2,  32'h0000_007F},
    {1'b0, 6'd3,  32'h1ABC_DE45},
    {1'b1, 6'd4,  32'h5FFF_FFFF},
    {1'b0, 6'd5,  32'h7000_0080},
    {1'b1, 6'd6,  32'hF123_4567},
    {1'b0, 6'd7,  32'h2000_0000},
    {1'b1, 6'd63, 32'hE000_0001}
  };

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [RA_W-1:0] exp_addr(input logic [IA_W-1:0] a);
    logic [SECT_W-1:0] ix;
    ix = a[SECT_LSB +: SECT_W];
    return {{(RA_W-SECT_LSB){1'b0}}, a[SECT_LSB-1:0]} + {m_off[ix], 7'b0};
  endfunction

  task automatic cfg_write(input int idx, input logic [OFF_W-1:0] off,
                           input logic [NETID_W-1:0] net, input bit leg);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = SECT_W'(idx); cfg_off = off; cfg_net = net; cfg_legal = leg;
    @(negedge clk);
    cfg_we = 1'b0;
    m_off[idx] = off; m_net[idx] = net; m_leg[idx] = leg;
  endtask

  // Check outputs for one request against the model (sampled 2 posedges after drive)
  task automatic check_resp(input bit wr, input logic [TAG_W-1:0] tag,
                            input logic [IA_W-1:0] a, input string rq);
    logic [SECT_W-1:0] ix;
    ix = a[SECT_LSB +: SECT_W];
    if (m_leg[ix]) begin
      chk(out_vld && !err_vld, {rq, " R6 forward valid"}, {out_vld, err_vld}, 2'b10);
      chk(out_tag == tag, {rq, " R6 tag"}, out_tag, tag);
      chk(out_wr == wr, {rq, " R6 wr"}, out_wr, wr);
      chk(out_addr == exp_addr(a), {rq, " R3 addr"}, out_addr, exp_addr(a));
      chk(out_net == m_net[ix], {rq, " R4 netid"}, out_net, m_net[ix]);
    end else begin
      chk(err_vld && !out_vld, {rq, " R5 error valid"}, {out_vld, err_vld}, 2'b01);
      chk(err_tag == tag, {rq, " R5 err tag"}, err_tag, tag);
    end
  endtask

  task automatic send_one(input bit wr, input logic [TAG_W-1:0] tag,
                          input logic [IA_W-1:0] a, input string rq);
    @(negedge clk);
    req_vld = 1'b1; req_wr = wr; req_tag = tag; req_addr = a;
    @(negedge clk);
    req_vld = 1'b0;
    @(negedge clk);
    check_resp(wr, tag, a, rq);
  endtask

  initial begin
    done = 1'b0;
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_off = '0; cfg_net = '0; cfg_legal = 1'b0;
    req_vld = 1'b0; req_wr = 1'b0; req_tag = '0; req_addr = '0;
    for (int i = 0; i < N_ENT; i++) begin
      m_off[i] = '0; m_net[i] = '0; m_leg[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(!out_vld && !err_vld, "R1 outputs idle in reset", {out_vld, err_vld}, 2'b00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!out_vld && !err_vld, "R1 outputs idle after reset", {out_vld, err_vld}, 2'b00);
    chk(!out_vld && !err_vld, "R9 no spurious output", {out_vld, err_vld}, 2'b00);

    // R1: empty table rejects
    send_one(1'b0, 6'd9, 32'h0000_0100, "R1 empty table");

    // Populate
    cfg_write(0,  45'h1000,          8'h11, 1'b1);
    cfg_write(1,  45'h1F_0000_0000,  8'h22, 1'b1);
    cfg_write(5,  45'h3,             8'h55, 1'b1);
    cfg_write(7,  45'h1FFF_FFFF_FFFF, 8'h77, 1'b1);
    cfg_write(15, 45'h12345,         8'hF0, 1'b1);

    // Vector walk (R2 index bits, R3 wrap at section 7, top index 15)
    for (int v = 0; v < N_VEC; v++) begin
      send_one(VEC[v][IA_W+TAG_W], VEC[v][IA_W +: TAG_W], VEC[v][IA_W-1:0], $sformatf("R2 vec%0d", v));
    end

    // R2: same section, different low bits -> same netid/offset
    send_one(1'b0, 6'd10, 32'h5000_1000, "R2 same section");

    // R7: lookup during write to same entry sees old contents
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'd5; cfg_off = 45'h40; cfg_net = 8'h99; cfg_legal = 1'b1;
    req_vld = 1'b1; req_wr = 1'b1; req_tag = 6'd20; req_addr = 32'h5000_0200;
    @(negedge clk);
    cfg_we = 1'b0; req_vld = 1'b0;
    @(negedge clk);
    check_resp(1'b1, 6'd20, 32'h5000_0200, "R7 old contents");
    m_off[5] = 45'h40; m_net[5] = 8'h99; m_leg[5] = 1'b1;
    send_one(1'b0, 6'd21, 32'h5000_0200, "R7 new contents");

    // R8: revoke section 1, neighbour 0 still fine
    cfg_write(1, 45'h0, 8'h00, 1'b0);
    send_one(1'b0, 6'd22, 32'h1000_0000, "R8 revoked");
    send_one(1'b1, 6'd23, 32'h0ABC_0000, "R8 neighbour");

    // R9: back-to-back mix, in order
    begin
      logic [IA_W-1:0]  ba [3];
      logic [TAG_W-1:0] bt [3];
      bit               bw [3];
      ba[0] = 32'h7000_0100; bt[0] = 6'd30; bw[0] = 1'b0;
      ba[1] = 32'h3000_0000; bt[1] = 6'd31; bw[1] = 1'b1;
      ba[2] = 32'hF000_0040; bt[2] = 6'd32; bw[2] = 1'b1;
      for (int c = 0; c < 5; c++) begin
        @(negedge clk);
        if (c >= 2) check_resp(bw[c-2], bt[c-2], ba[c-2], $sformatf("R9 burst%0d", c-2));
        if (c < 3) begin
          req_vld = 1'b1; req_wr = bw[c]; req_tag = bt[c]; req_addr = ba[c];
        end else begin
          req_vld = 1'b0;
        end
      end
      @(negedge clk);
      chk(!out_vld && !err_vld, "R9 idle after burst", {out_vld, err_vld}, 2'b00);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule